// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer

This block sits between a simple request port and one asynchronous DRAM of 256K eight-bit words. Row and column share a single 9-pin address bus. Each request carries an 18-bit word address, a direction flag and, for a store, one data byte. The block turns it into a full strobe cycle. It presents the upper half of the address as the row before the row strobe falls, switches the pins to the lower half, and then drops the column strobe. It then waits until both access-time minima have elapsed before it closes the cycle.

All four DRAM control lines are active low and are driven from registers. The row-cycle, row-access, column-access and column-cycle minima are given as parameters in nanoseconds and turned into cycle counts, rounded up, from the clock period. Writes use the early form: the write strobe and the data drive are set before the column strobe falls, and the output-enable line stays high. A read returns its byte on `rd_data` in the same cycle as the one-cycle `req_ack` pulse.

A free-running timer schedules one row-only refresh cycle per row, spread evenly so that all 512 rows are visited within the refresh period. A pending refresh is served only when no access is in progress, and it takes precedence over a waiting request.

Top module: `dram_seq_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high and `req_ack` is low.
- R2: The pins carry address bits [17:9] as the row when `dram_ras_n` falls, and bits [8:0] as the column when `dram_cas_n` falls.
- R3: For a write (`req_write`=1), `dram_we_n` falls before `dram_cas_n` falls and `dram_oe_n` stays high. The block drives `req_wdata` on `dram_dq`, and the byte is stored at the requested address.
- R4: For a read (`req_write`=0), `dram_oe_n` is low while `dram_cas_n` is low and `dram_we_n` stays high. The block releases `dram_dq`, and `rd_data` returns the byte last written to that address.
- R5: `dram_we_n` and `dram_oe_n` are never low at the same time.
- R6: Read data is captured no earlier than T_RAC after the row strobe falls and no earlier than T_CAC after the column strobe falls. `req_ack` is a single-cycle pulse in the capture cycle, and a request is held until it is acknowledged.
- R7: Successive falls of `dram_ras_n` are at least T_RC apart, and successive falls of `dram_cas_n` are at least T_PC apart.
- R8: A refresh is a cycle in which `dram_ras_n` falls and rises while `dram_cas_n` stays high. The row number steps 0, 1, 2, … and wraps after 511. Consecutive refreshes lie no more than one refresh interval (refresh period / 512), plus the length of one access, apart.
- R9: A refresh never starts inside an access, and a pending refresh is served before a waiting request. This holds even under back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address: row in [17:9], column in [8:0] |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read byte, valid with `req_ack` |
| dram_addr | output | 9 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | inout | 8 | Shared data bus |

## Verification
The hardest situation to reach from the ports is a refresh timer that expires while a new request is already waiting. If the priority were wrong, the refresh would be postponed only when the request stream never pauses. The stimulus therefore streams hundreds of reads with no idle cycle between them: each new request is raised on the same half-cycle that the previous acknowledge is seen. A short refresh interval makes the timer expire many times during the stream. The DRAM model measures every gap between refreshes and the row each refresh uses, and it refuses to drive valid data before the access minima have elapsed, so a capture that comes too early returns the wrong byte.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ROW,
        ST_COL,
        ST_CAS
    } seq_state_e;

    // round a nanosecond interval up to whole clock cycles
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_age_counter.sv
// Saturating count of cycles since the last start pulse.
module dram_age_counter #(
    parameter int unsigned W   = 4,
    parameter int unsigned MAX = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic [W-1:0] age
);
    localparam logic [W-1:0] MAX_V = W'(MAX);

    logic [W-1:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (start)
            age_d = W'(1);
        else if (age_q < MAX_V)
            age_d = age_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= MAX_V;
        else        age_q <= age_d;
    end

    assign age = age_q;

    a_r7_age_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        age_q <= MAX_V);
endmodule

// File: rtl/dram_refresh_timer.sv
// Interval timer plus row counter for row-only refresh.
module dram_refresh_timer #(
    parameter int unsigned INTERVAL = 1562,
    parameter int unsigned ROW_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             pend;
        logic [ROW_W-1:0] row;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (take) begin
            d.pend = 1'b0;
            d.row  = q.row + ROW_W'(1);
        end
        if (q.cnt == '0) begin
            d.cnt  = CW'(INTERVAL - 1);
            d.pend = 1'b1;
        end else begin
            d.cnt = q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= CW'(INTERVAL - 1);
            q.pend <= 1'b0;
            q.row  <= '0;
        end else begin
            q <= d;
        end
    end

    assign pending = q.pend;
    assign row     = q.row;

    a_r8_take_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> q.pend);
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int unsigned PIN_W             = 9,
    parameter int unsigned DATA_W            = 8,
    parameter int unsigned CLK_PERIOD_NS     = 10,
    parameter int unsigned T_RAC_NS          = 60,
    parameter int unsigned T_CAC_NS          = 15,
    parameter int unsigned T_RC_NS           = 110,
    parameter int unsigned T_PC_NS           = 35,
    parameter int unsigned REFRESH_PERIOD_NS = 8000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [2*PIN_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ack,
    output logic [DATA_W-1:0]    rd_data,
    output logic [PIN_W-1:0]     dram_addr,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic                 dram_oe_n,
    inout  wire  [DATA_W-1:0]    dram_dq
);
    localparam int unsigned RAC_CYC = ns_to_cycles(T_RAC_NS, CLK_PERIOD_NS);
    localparam int unsigned CAC_CYC = ns_to_cycles(T_CAC_NS, CLK_PERIOD_NS);
    localparam int unsigned RC_CYC  = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned PC_CYC  = ns_to_cycles(T_PC_NS, CLK_PERIOD_NS);
    localparam int unsigned AGE_MAX = max_u(max_u(RAC_CYC, CAC_CYC), max_u(RC_CYC, PC_CYC));
    localparam int unsigned AGE_W   = $clog2(AGE_MAX + 1);
    localparam int unsigned ROWS    = 1 << PIN_W;
    localparam int unsigned REF_CYC = REFRESH_PERIOD_NS / (ROWS * CLK_PERIOD_NS);

    localparam logic [AGE_W-1:0] RAC_A = AGE_W'(RAC_CYC);
    localparam logic [AGE_W-1:0] CAC_A = AGE_W'(CAC_CYC);
    localparam logic [AGE_W-1:0] RC_A  = AGE_W'(RC_CYC);
    localparam logic [AGE_W-1:0] PC_A  = AGE_W'(PC_CYC);

    typedef struct packed {
        seq_state_e          state;
        logic                ras_n;
        logic                cas_n;
        logic                we_n;
        logic                oe_n;
        logic                drive;
        logic                is_write;
        logic                is_ref;
        logic                ack;
        logic [PIN_W-1:0]    addr;
        logic [PIN_W-1:0]    col;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
    } ctl_t;

    ctl_t d, q;

    logic [AGE_W-1:0] ras_age, cas_age;
    logic             ras_fall, cas_fall;
    logic             ref_pending, ref_take;
    logic [PIN_W-1:0] ref_row;

    dram_age_counter #(.W(AGE_W), .MAX(AGE_MAX)) u_ras_age (
        .clk(clk), .rst_n(rst_n), .start(ras_fall), .age(ras_age));

    dram_age_counter #(.W(AGE_W), .MAX(AGE_MAX)) u_cas_age (
        .clk(clk), .rst_n(rst_n), .start(cas_fall), .age(cas_age));

    dram_refresh_timer #(.INTERVAL(REF_CYC), .ROW_W(PIN_W)) u_refresh (
        .clk(clk), .rst_n(rst_n), .take(ref_take), .pending(ref_pending), .row(ref_row));

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        ref_take = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (ref_pending) begin
                    // refresh wins, but only here between accesses
                    d.addr     = ref_row;
                    d.is_ref   = 1'b1;
                    d.is_write = 1'b0;
                    ref_take   = 1'b1;
                    d.state    = ST_SETUP;
                end else if (req_valid) begin
                    d.addr     = req_addr[2*PIN_W-1:PIN_W];
                    d.col      = req_addr[PIN_W-1:0];
                    d.is_ref   = 1'b0;
                    d.is_write = req_write;
                    d.we_n     = ~req_write;   // early write
                    d.drive    = req_write;
                    d.wdata    = req_wdata;
                    d.state    = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (ras_age >= RC_A) begin
                    d.ras_n = 1'b0;
                    d.state = ST_ROW;
                end
            end
            ST_ROW: begin
                if (q.is_ref) begin
                    if (ras_age >= RAC_A) begin
                        d.ras_n = 1'b1;
                        d.state = ST_IDLE;
                    end
                end else begin
                    d.addr  = q.col;
                    d.state = ST_COL;
                end
            end
            ST_COL: begin
                d.cas_n = 1'b0;
                d.oe_n  = q.is_write;
                d.state = ST_CAS;
            end
            ST_CAS: begin
                if ((ras_age >= RAC_A) && (cas_age >= CAC_A)) begin
                    d.ras_n = 1'b1;
                    d.cas_n = 1'b1;
                    d.oe_n  = 1'b1;
                    d.we_n  = 1'b1;
                    d.drive = 1'b0;
                    d.ack   = 1'b1;
                    if (!q.is_write)
                        d.rdata = dram_dq;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    assign ras_fall = q.ras_n & ~d.ras_n;
    assign cas_fall = q.cas_n & ~d.cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.ras_n    <= 1'b1;
            q.cas_n    <= 1'b1;
            q.we_n     <= 1'b1;
            q.oe_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ack    = q.ack;
    assign rd_data    = q.rdata;
    assign dram_addr  = q.addr;
    assign dram_ras_n = q.ras_n;
    assign dram_cas_n = q.cas_n;
    assign dram_we_n  = q.we_n;
    assign dram_oe_n  = q.oe_n;
    assign dram_dq    = q.drive ? q.wdata : 'z;

    a_r5_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_we_n && !dram_oe_n));

    a_r4_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> !q.drive);

    a_r6_capture_after_minima: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> ($past(ras_age) >= RAC_A && $past(cas_age) >= CAC_A));

    a_r6_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    a_r7_row_cycle_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $past(ras_age) >= RC_A);

    a_r7_col_cycle_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $past(cas_age) >= PC_A);

    a_r8_refresh_row_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && q.is_ref) |-> dram_cas_n);

    a_r9_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && ref_pending) |=> (q.is_ref && q.state == ST_SETUP));
endmodule

// File: tb/tb_dram_seq_ctrl.sv
module tb_dram_seq_ctrl;
    localparam int CLK      = 10;
    localparam int REF_PER  = 204800;             // short period for the bench
    localparam int REF_CYC  = REF_PER / (512 * CLK);
    localparam int GAP_MAX  = (REF_CYC + 30) * CLK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  rd_data;
    logic [8:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    wire  [7:0]  dram_dq;

    int checks = 0;
    int errors = 0;
    bit armed  = 1'b0;

    always #(CLK/2) clk = ~clk;

    dram_seq_ctrl #(
        .CLK_PERIOD_NS(CLK),
        .REFRESH_PERIOD_NS(REF_PER)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .rd_data(rd_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq(dram_dq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- DRAM model ----------------
    logic [7:0] mem [int];
    logic [8:0] m_row, m_col;
    logic [7:0] m_rdata = '0;
    bit  ras_ok = 1'b0, cas_ok = 1'b0, saw_cas = 1'b0;
    longint t_ras = -1000, t_cas = -1000, t_we = 0, t_ref = 0;
    int  last_key = -1;
    bit  last_wr  = 1'b0;
    int  ref_count = 0;
    logic [8:0] exp_ref_row = '0;

    assign dram_dq = (!dram_oe_n && !dram_cas_n && !dram_ras_n)
                     ? ((ras_ok && cas_ok) ? m_rdata : ~m_rdata) : 'z;

    always @(negedge dram_ras_n) begin
        if (armed) begin
            chk(($time - t_ras) >= 110, "R7", "row strobe spacing", $time - t_ras, 110);
            t_ras   = $time;
            m_row   = dram_addr;
            saw_cas = 1'b0;
        end
    end

    always @(negedge dram_ras_n) begin
        ras_ok = 1'b0;
        #59 ras_ok = 1'b1;
    end

    always @(negedge dram_cas_n) begin
        cas_ok = 1'b0;
        #14 cas_ok = 1'b1;
    end

    always @(negedge dram_we_n) t_we = $time;

    always @(negedge dram_cas_n) begin
        if (armed) begin
            int key;
            chk(($time - t_cas) >= 35, "R7", "column strobe spacing", $time - t_cas, 35);
            t_cas   = $time;
            chk(!dram_ras_n, "R2", "column strobe inside row cycle", dram_ras_n, 0);
            m_col   = dram_addr;
            saw_cas = 1'b1;
            key     = int'({m_row, m_col});
            last_key = key;
            last_wr  = !dram_we_n;
            if (!dram_we_n) begin
                chk(t_we < $time, "R3", "write strobe precedes column strobe", t_we, $time);
                chk(dram_oe_n, "R3", "output enable high on write", dram_oe_n, 1);
                mem[key] = dram_dq;
            end else begin
                m_rdata = mem.exists(key) ? mem[key] : 8'h00;
            end
        end
    end

    always @(posedge dram_ras_n) begin
        if (armed && !saw_cas) begin
            chk(m_row == exp_ref_row, "R8", "refresh row order", m_row, exp_ref_row);
            chk(($time - t_ref) <= GAP_MAX, "R8/R9", "refresh gap", $time - t_ref, GAP_MAX);
            t_ref = $time;
            exp_ref_row = exp_ref_row + 9'd1;
            ref_count++;
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            chk(!(!dram_we_n && !dram_oe_n), "R5", "write and output enable both low", 0, 1);
            if (!dram_oe_n) chk(dram_we_n, "R4", "write strobe high on read", dram_we_n, 1);
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [17:0] addr_of(input int kind, input int i);
        if (kind == 0) begin
            if (i < 18)       return 18'(1) << i;
            else if (i == 18) return 18'h00000;
            else              return 18'h3FFFF;
        end
        return 18'((i * 12347 + 77) & 32'h3FFFF);
    endfunction

    function automatic logic [7:0] data_of(input logic [17:0] a);
        return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'hA5;
    endfunction

    // requests issued back to back: the next request is raised on the
    // half-cycle where the previous acknowledge is seen
    task automatic run_stream(input bit wr, input int kind, input int n, input bit inv);
        for (int i = 0; i < n; i++) begin
            logic [17:0] a;
            logic [7:0]  e;
            int cyc;
            a = addr_of(kind, i % ((kind == 0) ? 20 : 64));
            e = data_of(a) ^ (inv ? 8'hFF : 8'h00);
            req_valid = 1'b1;
            req_write = wr;
            req_addr  = a;
            req_wdata = e;
            cyc = 0;
            do begin
                @(negedge clk);
                cyc++;
                if (cyc == 1)
                    chk(!req_ack, "R6", "acknowledge is a single pulse", req_ack, 0);
            end while (!req_ack && cyc < 100);
            chk(req_ack, "R6", "acknowledge arrives", cyc, 40);
            chk(last_key == int'(a), "R2", "row/column address seen by DRAM", last_key, a);
            chk(last_wr == wr, "R3/R4", "access direction", last_wr, wr);
            if (!wr)
                chk(rd_data == e, "R4/R6", "read data", rd_data, e);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes idle in reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        chk(!req_ack, "R1", "no acknowledge in reset", req_ack, 0);
        rst_n = 1'b1;
        armed = 1'b1;
        t_ref = $time;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n, "R1", "strobes idle after reset",
            {dram_ras_n, dram_cas_n}, 2'b11);

        run_stream(1'b1, 0, 20, 1'b0);    // walking bits, zero, all ones
        run_stream(1'b1, 1, 64, 1'b0);    // scattered pattern
        run_stream(1'b0, 0, 20, 1'b0);
        run_stream(1'b0, 1, 64, 1'b0);
        run_stream(1'b1, 0, 20, 1'b1);    // overwrite with inverted data
        run_stream(1'b0, 0, 20, 1'b1);
        run_stream(1'b0, 1, 400, 1'b0);   // long stream against refresh (R9)

        repeat (22000) @(negedge clk);    // idle: refresh row counter wraps
        chk(ref_count > 512, "R8", "refresh count covers all rows", ref_count, 513);
        chk(($time - t_ref) <= GAP_MAX, "R8", "refresh continues when idle", $time - t_ref, GAP_MAX);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule